// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This block sits beside the serial front end of a byte-addressed nonvolatile memory slave and owns every decision about whether a write may happen. It keeps the 8-bit status byte: a write-enable latch, a two-bit protected-range selector and a bit that lets the hardware protect pin guard the status byte. The front end reports command events as one-cycle pulses. These are: an enable command decoded, a disable command decoded, a status data byte completed (with that byte), a memory data byte completed, and the end of a transaction (chip select rising).

The unit answers two questions. Is a status write allowed right now? May the byte address presented on the query port be written? The query port is combinational, so the front end can check each byte address of a burst in the cycle it commits that byte. The status byte output is registered and is read back by the front end during a status read. Nonvolatile retention is modelled as plain registers that clear on reset.

Top module: `wrprot_unit`

## Requirements
- R1: The status byte holds the pin-guard enable in bit 7, the range selector in bits 3:2 (bit 3 high) and the write-enable latch in bit 1. Bits 6:4 and bit 0 always read 0, even after a status write of 0xFF.
- R2: After reset the status byte is 0x00, so writes start disabled.
- R3: The latch (bit 1) becomes 1 only on the cycle after an enable event. Bit 1 of a status data byte never sets or keeps the latch.
- R4: A disable, status-write or memory-write event marks the transaction. The latch then clears on the cycle after the chip-select-rise event that ends it, and not before. A chip-select rise that ends an enable-only transaction leaves the latch at 1.
- R5: The protected range decodes from the selector as follows: 00 protects nothing, 01 protects 0x1800–0x1FFF, 10 protects 0x1000–0x1FFF and 11 protects the whole array.
- R6: mem_wr_ok is 1 only when the latch is 1 and the query address lies outside the protected range.
- R7: st_wr_ok is 0 when the latch is 0, or when bit 7 is 1 and wp_n is low. A status data byte arriving while st_wr_ok is 0 leaves bits 7 and 3:2 unchanged.
- R8: While bit 7 is 0, wp_n has no effect and a status write with the latch set is allowed.
- R9: An allowed status write takes wp_n as it is in the data-byte cycle. It commits bits 7 and 3:2 on the next cycle, before the chip-select rise.
- R10: mem_wr_ok follows qry_addr in the same cycle. A range change made by a status write affects queries only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_set_en | input | 1 | Enable command decoded (pulse) |
| ev_clr_en | input | 1 | Disable command decoded (pulse) |
| ev_st_wr | input | 1 | Status data byte completed (pulse) |
| st_data | input | 8 | Status data byte, valid with ev_st_wr |
| ev_mem_wr | input | 1 | Memory data byte completed (pulse) |
| ev_cs_rise | input | 1 | Transaction ended by chip-select rise (pulse) |
| wp_n | input | 1 | Hardware protect pin, active low |
| qry_addr | input | 13 | Byte address to check |
| mem_wr_ok | output | 1 | Query address may be written |
| st_wr_ok | output | 1 | A status write is allowed now |
| status_byte | output | 8 | Status byte for read-back |

## Verification
Two functions can land in the same cycle: the commit of a status data byte and the transaction-end clear of the latch. The bench provokes this by pulsing the status-write event and the chip-select-rise event together after an enable. It then requires that the new range bits land and that the latch drops, both on the following cycle. In that same cycle a query is made into the range being newly protected. The old selector must still allow the write, and the new one must refuse it one cycle later.

// File: rtl/wrprot_pkg.sv
`timescale 1ns/1ps
package wrprot_pkg;
    localparam int STS_W      = 8;
    localparam int STS_GUARD  = 7;
    localparam int STS_SEL_HI = 3;
    localparam int STS_SEL_LO = 2;
    localparam int STS_LATCH  = 1;

    typedef struct packed {
        logic latch;
        logic marked;
    } latch_st_t;

    typedef struct packed {
        logic       guard;
        logic [1:0] sel;
    } cfg_st_t;
endpackage

// File: rtl/wrprot_latch.sv
`timescale 1ns/1ps
module wrprot_latch
    import wrprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  logic st_wr,
    input  logic mem_wr,
    input  logic cs_rise,
    output logic latch
);
    latch_st_t st_d, st_q;
    logic      wr_kind;

    always_comb begin
        wr_kind = clr_en | st_wr | mem_wr;
        st_d    = st_q;
        if (wr_kind) st_d.marked = 1'b1;
        if (set_en)  st_d.latch  = 1'b1;
        if (cs_rise) begin
            if (st_q.marked || wr_kind) st_d.latch = 1'b0;
            st_d.marked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch = st_q.latch;
endmodule

// File: rtl/wrprot_status.sv
`timescale 1ns/1ps
module wrprot_status
    import wrprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_wr,
    input  logic       new_guard,
    input  logic [1:0] new_sel,
    input  logic       latch,
    input  logic       wp_n,
    output logic       guard,
    output logic [1:0] sel,
    output logic       allow
);
    cfg_st_t cfg_d, cfg_q;
    logic    pin_block;

    always_comb begin
        pin_block = cfg_q.guard & ~wp_n;
        allow     = latch & ~pin_block;
        cfg_d     = cfg_q;
        if (st_wr && allow) begin
            cfg_d.guard = new_guard;
            cfg_d.sel   = new_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign guard = cfg_q.guard;
    assign sel   = cfg_q.sel;
endmodule

// File: rtl/wrprot_range.sv
`timescale 1ns/1ps
module wrprot_range #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

    always_comb begin
        unique case (sel)
            2'b00:   prot = 1'b0;
            2'b01:   prot = (addr >= QTR_BASE);
            2'b10:   prot = (addr >= HALF_BASE);
            default: prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/wrprot_unit.sv
`timescale 1ns/1ps
module wrprot_unit
    import wrprot_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_set_en,
    input  logic              ev_clr_en,
    input  logic              ev_st_wr,
    input  logic [7:0]        st_data,
    input  logic              ev_mem_wr,
    input  logic              ev_cs_rise,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              mem_wr_ok,
    output logic              st_wr_ok,
    output logic [7:0]        status_byte
);
    logic       latch;
    logic       guard;
    logic [1:0] sel;
    logic       prot;
    logic       unused_bits;

    assign unused_bits = ^{st_data[6:4], st_data[1:0]};

    wrprot_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ev_set_en),
        .clr_en  (ev_clr_en),
        .st_wr   (ev_st_wr),
        .mem_wr  (ev_mem_wr),
        .cs_rise (ev_cs_rise),
        .latch   (latch)
    );

    wrprot_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_wr     (ev_st_wr),
        .new_guard (st_data[STS_GUARD]),
        .new_sel   (st_data[STS_SEL_HI:STS_SEL_LO]),
        .latch     (latch),
        .wp_n      (wp_n),
        .guard     (guard),
        .sel       (sel),
        .allow     (st_wr_ok)
    );

    wrprot_range #(.ADDR_W(ADDR_W)) u_range (
        .sel  (sel),
        .addr (qry_addr),
        .prot (prot)
    );

    always_comb begin
        status_byte                        = '0;
        status_byte[STS_GUARD]             = guard;
        status_byte[STS_SEL_HI:STS_SEL_LO] = sel;
        status_byte[STS_LATCH]             = latch;
        mem_wr_ok                          = latch & ~prot;
    end
endmodule

// File: rtl/wrprot_unit_chk.sv
`timescale 1ns/1ps
module wrprot_unit_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_set_en,
    input logic              ev_clr_en,
    input logic              ev_st_wr,
    input logic [7:0]        st_data,
    input logic              ev_mem_wr,
    input logic              ev_cs_rise,
    input logic              wp_n,
    input logic [ADDR_W-1:0] qry_addr,
    input logic              mem_wr_ok,
    input logic              st_wr_ok,
    input logic [7:0]        status_byte
);
    AST_LATCH_ONLY_BY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[1]) |-> $past(ev_set_en)); // R3

    AST_END_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cs_rise && (ev_clr_en || ev_st_wr || ev_mem_wr)) |=> !status_byte[1]); // R4

    AST_FULL_RANGE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !mem_wr_ok); // R5

    AST_ARRAY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_ok |-> status_byte[1]); // R6

    AST_BLOCKED_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_st_wr && !st_wr_ok) |=> ($stable(status_byte[7]) && $stable(status_byte[3:2]))); // R7

    AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_byte[7] && status_byte[1]) |-> st_wr_ok); // R8
endmodule

bind wrprot_unit wrprot_unit_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/wrprot_unit_tb_top.sv
`timescale 1ns/1ps
module wrprot_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_set_en = 1'b0, ev_clr_en = 1'b0, ev_st_wr = 1'b0;
    logic        ev_mem_wr = 1'b0, ev_cs_rise = 1'b0, wp_n = 1'b1;
    logic [7:0]  st_data = '0;
    logic [12:0] qry_addr = '0;
    logic        mem_wr_ok, st_wr_ok;
    logic [7:0]  status_byte;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wrprot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ev_set_en(ev_set_en), .ev_clr_en(ev_clr_en),
        .ev_st_wr(ev_st_wr), .st_data(st_data), .ev_mem_wr(ev_mem_wr),
        .ev_cs_rise(ev_cs_rise), .wp_n(wp_n), .qry_addr(qry_addr),
        .mem_wr_ok(mem_wr_ok), .st_wr_ok(st_wr_ok), .status_byte(status_byte)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cs_end();
        @(negedge clk); ev_cs_rise = 1'b1;
        @(negedge clk); ev_cs_rise = 1'b0;
    endtask

    task automatic cmd_set();
        @(negedge clk); ev_set_en = 1'b1;
        @(negedge clk); ev_set_en = 1'b0;
        cs_end();
    endtask

    task automatic st_byte(input logic [7:0] d);
        @(negedge clk); ev_st_wr = 1'b1; st_data = d;
        @(negedge clk); ev_st_wr = 1'b0;
    endtask

    task automatic query(input logic [12:0] a, input logic exp, input string req);
        qry_addr = a; #1;
        check(req, {15'd0, mem_wr_ok}, {15'd0, exp});
    endtask

    task automatic t_reset();
        do_reset();
        check("R2 reset status", {8'd0, status_byte}, 16'h0000);
        check("R2 reset mem_wr_ok", {15'd0, mem_wr_ok}, 16'h0000);
    endtask

    task automatic t_layout();
        do_reset();
        cmd_set();
        check("R3 latch after enable", {8'd0, status_byte}, 16'h0002);
        st_byte(8'hFF);
        check("R1 R9 layout after byte", {8'd0, status_byte}, 16'h008E);
        cs_end();
        check("R1 R4 after cs", {8'd0, status_byte}, 16'h008C);
        cmd_set();
        st_byte(8'h02);
        check("R9 commit before cs", {8'd0, status_byte}, 16'h0002);
        cs_end();
        check("R3 data bit1 ignored", {8'd0, status_byte}, 16'h0000);
    endtask

    task automatic t_latch();
        do_reset();
        cmd_set();
        cs_end();
        check("R4 enable-only cs keeps latch", {8'd0, status_byte}, 16'h0002);
        @(negedge clk); ev_clr_en = 1'b1;
        @(negedge clk); ev_clr_en = 1'b0;
        check("R4 disable waits for cs", {8'd0, status_byte}, 16'h0002);
        cs_end();
        check("R4 disable clears at cs", {8'd0, status_byte}, 16'h0000);
        cmd_set();
        @(negedge clk); ev_mem_wr = 1'b1;
        @(negedge clk); ev_mem_wr = 1'b0;
        check("R4 mem write waits for cs", {8'd0, status_byte}, 16'h0002);
        cs_end();
        check("R4 mem write clears at cs", {8'd0, status_byte}, 16'h0000);
    endtask

    task automatic t_ranges();
        do_reset();
        query(13'h0000, 1'b0, "R6 no latch blocks");
        cmd_set();
        query(13'h1FFF, 1'b1, "R5 sel00 top open");
        st_byte(8'h04);
        cs_end();
        cmd_set();
        query(13'h17FF, 1'b1, "R5 sel01 below quarter");
        query(13'h1800, 1'b0, "R5 sel01 quarter base");
        st_byte(8'h08);
        cs_end();
        cmd_set();
        query(13'h0FFF, 1'b1, "R5 sel10 below half");
        query(13'h1000, 1'b0, "R5 sel10 half base");
        st_byte(8'h0C);
        cs_end();
        cmd_set();
        query(13'h0000, 1'b0, "R5 sel11 bottom");
        query(13'h1FFF, 1'b0, "R5 sel11 top");
    endtask

    task automatic t_pin();
        do_reset();
        check("R7 no latch st_wr_ok", {15'd0, st_wr_ok}, 16'h0000);
        st_byte(8'h0C);
        cs_end();
        check("R7 no latch keeps cfg", {8'd0, status_byte}, 16'h0000);
        cmd_set();
        st_byte(8'h80);
        cs_end();
        cmd_set();
        wp_n = 1'b0; #1;
        check("R7 pin blocks st_wr_ok", {15'd0, st_wr_ok}, 16'h0000);
        st_byte(8'h8C);
        check("R7 pin-blocked keeps cfg", {8'd0, status_byte}, 16'h0082);
        cs_end();
        wp_n = 1'b1;
        cmd_set();
        st_byte(8'h04);
        cs_end();
        check("R9 pin high allows", {8'd0, status_byte}, 16'h0004);
        cmd_set();
        wp_n = 1'b0; #1;
        check("R8 guard off pin ignored", {15'd0, st_wr_ok}, 16'h0001);
        st_byte(8'h08);
        cs_end();
        check("R8 guard off write lands", {8'd0, status_byte}, 16'h0008);
        wp_n = 1'b1;
    endtask

    task automatic t_same_cycle();
        do_reset();
        cmd_set();
        @(negedge clk);
        qry_addr = 13'h1900; st_data = 8'h84; ev_st_wr = 1'b1; ev_cs_rise = 1'b1; #1;
        check("R10 old range in commit cycle", {15'd0, mem_wr_ok}, 16'h0001);
        @(negedge clk); ev_st_wr = 1'b0; ev_cs_rise = 1'b0; #1;
        check("R9 R4 commit and clear together", {8'd0, status_byte}, 16'h0084);
        check("R10 new range next cycle", {15'd0, mem_wr_ok}, 16'h0000);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_layout();
        t_latch();
        t_ranges();
        t_pin();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule